// File: doc/BRIEF.md
# Bang-bang delay-locked loop control word generator

This block is the digital half of an all-digital delay-locked loop. Once per rising edge of the reference clock it samples the level of the delayed clock that comes back from the delay line. That one-bit early/late decision steps a 6-bit control word up or down by one. The control word drives a binary-weighted delay line, where bit n enables a segment of weight 2^n. A larger code gives a longer delay.

A synchronous reset forces the code to zero, which is the shortest delay. From there the search only climbs, so the loop settles on the first period boundary it meets and cannot lock to a multiple of the period. At the balance point the code toggles between two neighbouring values every reference cycle, so the residual error is one step of the delay line.

A lock flag reports a sustained run of alternating decisions. A range error flag reports a delay line that cannot reach one period even at its maximum code. An enable input freezes the whole loop.

Top module: `dll_delay_ctrl`

## Requirements
- R1: While `srst` is high at a rising edge of `clk_ref`, the next state has `ctrl_word` = 0, `locked` = 0 and `range_error` = 0.
- R2: At each rising edge with `enable` high, the sampled `dly_clk` sets the direction of the step. Level 1 means the delay is shorter than a period, and the code goes up by one. Level 0 means the delay is longer than a period, and the code goes down by one.
- R3: `ctrl_word` changes by at most one count per edge.
- R4: The code saturates and never wraps. An up decision at 63 leaves it at 63, and a down decision at 0 leaves it at 0.
- R5: After reset, with a delay line that is short at code 0 and first becomes long at code K, the code rises by one on each edge up to K. It then alternates between K-1 and K on every edge.
- R6: `locked` goes high after the edge that completes 8 consecutive alternations of the decision. The first decision after reset does not count as an alternation. `locked` is never high before that edge.
- R7: While `locked` is high, 4 consecutive identical decisions clear it after the fourth.
- R8: `range_error` goes high after the 64th consecutive enabled edge at which the code is 63 and the decision is up. It then stays high until `srst`.
- R9: While `enable` is low, `ctrl_word`, `locked` and `range_error` hold their values whatever `dly_clk` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; every decision is taken on its rising edge |
| srst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | High lets the loop run; low freezes it |
| dly_clk | input | 1 | Delayed clock returned from the delay line |
| ctrl_word | output | 6 | Delay line code; bit n enables a segment of weight 2^n |
| locked | output | 1 | High while the loop dithers around its target |
| range_error | output | 1 | Sticky flag: the delay stayed short at maximum code |

## Verification
On every cycle the assertions check four things: the code moves by at most one count, it saturates at both ends, a disabled loop holds all its state, and reset clears everything. They also check that a rising range error coincides with the top code.

Some behaviour only shows up in the bench's closed-loop scenarios with a behavioural delay model. These are the monotonic climb from zero to the first period boundary, the one-step dither, and the exact edges at which the lock flag rises and falls. The 64-edge timing of the range error also depends on long input histories and is checked there.

// File: rtl/dll_delay_ctrl.sv
module dll_delay_ctrl #(
  parameter int CW         = 6,
  parameter int LOCK_ALTS  = 8,
  parameter int UNLOCK_RUN = 4,
  parameter int RANGE_HOLD = 64
) (
  input  logic          clk_ref,
  input  logic          srst,
  input  logic          enable,
  input  logic          dly_clk,
  output logic [CW-1:0] ctrl_word,
  output logic          locked,
  output logic          range_error
);
  localparam logic [CW-1:0] CODE_MAX = '1;
  localparam int AW = $clog2(LOCK_ALTS + 1);
  localparam int RW = $clog2(UNLOCK_RUN + 1);
  localparam int HW = $clog2(RANGE_HOLD + 1);

  logic          up;
  logic          prev_up;
  logic          have_prev;
  logic          flip;
  logic          at_max;
  logic          at_min;
  logic [AW-1:0] alt_cnt;
  logic [RW-1:0] run_cnt;
  logic [HW-1:0] hold_cnt;

  assign up     = dly_clk;
  assign flip   = have_prev && (up != prev_up);
  assign at_max = (ctrl_word == CODE_MAX);
  assign at_min = (ctrl_word == '0);

  always_ff @(posedge clk_ref) begin
    if (srst) begin
      ctrl_word   <= '0;
      locked      <= 1'b0;
      range_error <= 1'b0;
      prev_up     <= 1'b0;
      have_prev   <= 1'b0;
      alt_cnt     <= '0;
      run_cnt     <= '0;
      hold_cnt    <= '0;
    end else if (enable) begin
      prev_up   <= up;
      have_prev <= 1'b1;

      if (up && !at_max)
        ctrl_word <= ctrl_word + 1'b1;
      else if (!up && !at_min)
        ctrl_word <= ctrl_word - 1'b1;

      if (flip) begin
        run_cnt <= RW'(1);
        if (alt_cnt != AW'(LOCK_ALTS))
          alt_cnt <= alt_cnt + 1'b1;
        if (alt_cnt == AW'(LOCK_ALTS - 1))
          locked <= 1'b1;
      end else begin
        alt_cnt <= '0;
        if (run_cnt != RW'(UNLOCK_RUN))
          run_cnt <= run_cnt + 1'b1;
        if (run_cnt == RW'(UNLOCK_RUN - 1))
          locked <= 1'b0;
      end

      if (at_max && up) begin
        if (hold_cnt != HW'(RANGE_HOLD))
          hold_cnt <= hold_cnt + 1'b1;
        if (hold_cnt == HW'(RANGE_HOLD - 1))
          range_error <= 1'b1;
      end else begin
        hold_cnt <= '0;
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk_ref)
    srst |=> (ctrl_word == '0) && !locked && !range_error);

  p_one_step_r3: assert property (@(posedge clk_ref) disable iff (srst)
    (ctrl_word == $past(ctrl_word)) || (ctrl_word == $past(ctrl_word) + 1'b1) ||
    (ctrl_word + 1'b1 == $past(ctrl_word)));

  p_sat_top_r4: assert property (@(posedge clk_ref) disable iff (srst)
    (enable && up && at_max) |=> (ctrl_word == CODE_MAX));

  p_sat_bottom_r4: assert property (@(posedge clk_ref) disable iff (srst)
    (enable && !up && at_min) |=> (ctrl_word == '0));

  p_freeze_r9: assert property (@(posedge clk_ref) disable iff (srst)
    !enable |=> $stable(ctrl_word) && $stable(locked) && $stable(range_error));

  p_range_at_top_r8: assert property (@(posedge clk_ref) disable iff (srst)
    $rose(range_error) |-> at_max);
endmodule

// File: tb/tb_dll_delay_ctrl.sv
module tb_dll_delay_ctrl;
  logic       clk_ref = 1'b0;
  logic       srst = 1'b1;
  logic       enable = 1'b1;
  logic       dly_clk = 1'b1;
  logic [5:0] ctrl_word;
  logic       locked;
  logic       range_error;
  bit         model_on = 1'b0;
  int         n_chk = 0;
  int         n_fail = 0;

  dll_delay_ctrl dut (
    .clk_ref(clk_ref), .srst(srst), .enable(enable), .dly_clk(dly_clk),
    .ctrl_word(ctrl_word), .locked(locked), .range_error(range_error)
  );

  always #2 clk_ref = ~clk_ref;

  function automatic logic model_short(input int code);
    return (2100 + 60 * code) < 4000;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_ref);
    @(negedge clk_ref);
    if (model_on) dly_clk = model_short(int'(ctrl_word));
  endtask

  task automatic do_reset();
    srst = 1'b1;
    tick();
    tick();
    chk(ctrl_word == 0, "R1 code", ctrl_word, 0);
    chk(locked == 0, "R1 lock", locked, 0);
    chk(range_error == 0, "R1 range", range_error, 0);
    srst = 1'b0;
    if (model_on) dly_clk = model_short(0);
  endtask

  task automatic t_acquire();
    int prev;
    model_on = 1'b1;
    do_reset();
    for (int k = 1; k <= 32; k++) begin
      tick();
      chk(ctrl_word == k, "R5 climb", ctrl_word, k);
      chk(locked == 0, "R6 no early lock", locked, 0);
    end
    for (int k = 33; k <= 39; k++) tick();
    chk(locked == 0, "R6 before 8th alternation", locked, 0);
    tick();
    chk(locked == 1, "R6 lock at 8th alternation", locked, 1);
    prev = ctrl_word;
    for (int k = 0; k < 16; k++) begin
      tick();
      chk(ctrl_word == 31 || ctrl_word == 32, "R5 dither range", ctrl_word, 31);
      chk(ctrl_word == prev + 1 || ctrl_word + 1 == prev, "R3 one step", ctrl_word, prev);
      prev = ctrl_word;
    end
  endtask

  task automatic t_unlock();
    if (ctrl_word != 31) tick();
    model_on = 1'b0;
    dly_clk = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      tick();
      chk(ctrl_word == 31 + k, "R2 up step", ctrl_word, 31 + k);
    end
    chk(locked == 1, "R7 lock held after 3 same", locked, 1);
    tick();
    chk(locked == 0, "R7 lock cleared after 4 same", locked, 0);
    dly_clk = 1'b0;
    tick();
    chk(ctrl_word == 34, "R2 down step", ctrl_word, 34);
  endtask

  task automatic t_enable();
    enable = 1'b0;
    for (int k = 0; k < 5; k++) begin
      dly_clk = k[0];
      tick();
      chk(ctrl_word == 34, "R9 frozen code", ctrl_word, 34);
      chk(locked == 0, "R9 frozen lock", locked, 0);
    end
    enable = 1'b1;
  endtask

  task automatic t_floor();
    model_on = 1'b0;
    dly_clk = 1'b0;
    do_reset();
    dly_clk = 1'b0;
    for (int k = 0; k < 6; k++) tick();
    chk(ctrl_word == 0, "R4 floor no wrap", ctrl_word, 0);
  endtask

  task automatic t_range();
    dly_clk = 1'b1;
    do_reset();
    dly_clk = 1'b1;
    for (int k = 0; k < 126; k++) tick();
    chk(ctrl_word == 63, "R4 top saturate", ctrl_word, 63);
    chk(range_error == 0, "R8 not before 64 holds", range_error, 0);
    tick();
    chk(range_error == 1, "R8 set at 64th hold", range_error, 1);
    chk(ctrl_word == 63, "R4 top no wrap", ctrl_word, 63);
    dly_clk = 1'b0;
    tick();
    chk(ctrl_word == 62, "R2 down from top", ctrl_word, 62);
    chk(range_error == 1, "R8 sticky", range_error, 1);
    do_reset();
  endtask

  initial begin
    fork
      begin
        t_acquire();
        t_unlock();
        t_enable();
        t_floor();
        t_range();
      end
      begin
        repeat (20000) @(posedge clk_ref);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule